// File: doc/BRIEF.md
# Mode-Aware Load Formatter and Right Shifter

This block sits at the write-back end of a 64-bit integer datapath. It shapes two kinds of result into a register value. The first is data coming back from memory, which it lane-selects and extends to 64 bits. The second is a right shift, which it computes with a fill bit taken from either a 32-bit or a 64-bit operand width.

A mode input picks between native 64-bit operation and a 32-bit compatibility mode. The mode changes how word loads are extended. It also makes every operation that exists only in 64-bit mode raise an illegal-instruction trap, and a trapped operation writes nothing.

Each request is a single cycle marked by a valid input. One cycle later the block presents one of three results:
- a registered write value with its valid,
- a trap pulse,
- an alignment-fault pulse.

Top module: `lsf_top`

## Requirements
- R1: While rst_ni is low, and until the first request after reset, wr_valid_o, trap_o and align_fault_o are 0 and wr_data_o is 0.
- R2: For a load (op_i=0) or shift (op_i=1) that neither traps nor faults, wr_valid_o is 1 exactly in the cycle after req_valid_i. Cycles without a request give wr_valid_o=0.
- R3: In 64-bit mode (mode64_i=1), a word load (size_i=2) sign-extends the selected 32-bit lane from its bit 31, whatever signed_i is.
- R4: In 32-bit mode (mode64_i=0), a word load zero-extends the selected lane, whatever signed_i is.
- R5: Byte (size_i=0) and halfword (size_i=1) loads take the lane that starts at byte addr_off_i*1 of data_i, little-endian. They sign-extend when signed_i=1 and zero-extend when signed_i=0.
- R6: A doubleword load (size_i=3) in 64-bit mode returns data_i unchanged.
- R7: A load whose addr_off_i is not a multiple of the operand size in bytes (1, 2, 4 or 8) gives a one-cycle align_fault_o and no write.
- R8: A shift with shift_wide_i=0 shifts data_i[31:0] right by shamt_i[4:0]. The fill is bit 31 when signed_i=1 and 0 otherwise. Bits 63:32 of the result repeat result bit 31 when signed_i=1 and are 0 otherwise.
- R9: A shift with shift_wide_i=1 shifts all 64 bits right by shamt_i. The fill is bit 63 when signed_i=1 and 0 otherwise.
- R10: In 32-bit mode, a doubleword load, a shift with shift_wide_i=1, or a 64-bit-only operation (op_i=2) gives a one-cycle trap_o. It gives no write, and no align_fault_o even when the access is also misaligned.
- R11: op_i=2 in 64-bit mode, and op_i=3 in either mode, give no write, no trap and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid for this cycle |
| op_i | input | 2 | 0 load, 1 shift right, 2 other 64-bit-only op, 3 no operation |
| mode64_i | input | 1 | 1 native 64-bit mode, 0 32-bit compatibility mode |
| size_i | input | 2 | Load size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| signed_i | input | 1 | Signed load / arithmetic shift |
| addr_off_i | input | 3 | Byte offset of the access within the 64-bit word |
| shamt_i | input | 6 | Shift amount |
| shift_wide_i | input | 1 | Shift operand width: 0 for 32 bits, 1 for 64 bits |
| data_i | input | 64 | Memory word for loads, operand for shifts |
| wr_valid_o | output | 1 | Register write valid |
| wr_data_o | output | 64 | Register write value |
| trap_o | output | 1 | Illegal-instruction trap pulse |
| align_fault_o | output | 1 | Alignment fault pulse |

## Verification
The bench builds the block with its default widths: a 64-bit datapath and a 32-bit narrow operand. At those values every one of the eight byte lanes is reachable. So are both fill positions, bit 31 and bit 63, and shift amounts of 32 and above, which the narrow path must wrap. Under these widths each operation is run in both modes. This includes the overlap cases where a misaligned doubleword load in 32-bit mode must report the trap rather than the fault.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SHR  = 2'd1,
    OP_WIDE = 2'd2,
    OP_NONE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } size_e;
endpackage

// File: rtl/lsf_load_fmt.sv
module lsf_load_fmt
  import lsf_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  localparam int OFF_W   = $clog2(DATA_W / 8)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [OFF_W-1:0]  off_i,
  input  size_e             size_i,
  input  logic              signed_i,
  input  logic              mode64_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int HALF_W = 16;

  logic [DATA_W-1:0] lane;
  assign lane = data_i >> {off_i, 3'b000};

  always_comb begin
    unique case (size_i)
      SZ_B: res_o = signed_i ? {{(DATA_W-8){lane[7]}}, lane[7:0]}
                             : {{(DATA_W-8){1'b0}}, lane[7:0]};
      SZ_H: res_o = signed_i ? {{(DATA_W-HALF_W){lane[HALF_W-1]}}, lane[HALF_W-1:0]}
                             : {{(DATA_W-HALF_W){1'b0}}, lane[HALF_W-1:0]};
      // word extension follows the mode, not the signed flag
      SZ_W: res_o = mode64_i ? {{(DATA_W-NARROW_W){lane[NARROW_W-1]}}, lane[NARROW_W-1:0]}
                             : {{(DATA_W-NARROW_W){1'b0}}, lane[NARROW_W-1:0]};
      default: res_o = data_i;
    endcase
  end
endmodule

// File: rtl/lsf_shr.sv
module lsf_shr #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  localparam int SH_W    = $clog2(DATA_W),
  localparam int NSH_W   = $clog2(NARROW_W)
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic              wide_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] res_o
);
  logic signed [NARROW_W-1:0] n_src;
  logic        [NARROW_W-1:0] n_res;
  logic signed [DATA_W-1:0]   w_src;
  logic        [DATA_W-1:0]   w_res;

  assign n_src = opnd_i[NARROW_W-1:0];
  assign w_src = opnd_i;

  always_comb begin
    if (arith_i) n_res = n_src >>> shamt_i[NSH_W-1:0];
    else         n_res = opnd_i[NARROW_W-1:0] >> shamt_i[NSH_W-1:0];
    if (arith_i) w_res = w_src >>> shamt_i;
    else         w_res = opnd_i >> shamt_i;
  end

  assign res_o = wide_i ? w_res
               : {{(DATA_W-NARROW_W){arith_i & n_res[NARROW_W-1]}}, n_res};
endmodule

// File: rtl/lsf_check.sv
module lsf_check
  import lsf_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int OFF_W = $clog2(DATA_W / 8)
) (
  input  op_e              op_i,
  input  size_e            size_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             mode64_i,
  input  logic             shift_wide_i,
  output logic             trap_o,
  output logic             misalign_o
);
  logic [OFF_W-1:0] mask;

  always_comb begin
    unique case (size_i)
      SZ_B:    mask = '0;
      SZ_H:    mask = OFF_W'(1);
      SZ_W:    mask = OFF_W'(3);
      default: mask = '1;
    endcase
  end

  assign misalign_o = (op_i == OP_LOAD) && ((off_i & mask) != '0);
  assign trap_o     = !mode64_i && ((op_i == OP_WIDE)
                                 || (op_i == OP_LOAD && size_i == SZ_D)
                                 || (op_i == OP_SHR && shift_wide_i));
endmodule

// File: rtl/lsf_top.sv
module lsf_top
  import lsf_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  localparam int OFF_W   = $clog2(DATA_W / 8),
  localparam int SH_W    = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        op_i,
  input  logic              mode64_i,
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  input  logic [OFF_W-1:0]  addr_off_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic              shift_wide_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              trap_o,
  output logic              align_fault_o
);
  op_e               op;
  size_e             sz;
  logic [DATA_W-1:0] ld_res, sh_res;
  logic              trap, misalign, do_wr;

  assign op = op_e'(op_i);
  assign sz = size_e'(size_i);

  lsf_load_fmt #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_load (
    .data_i(data_i), .off_i(addr_off_i), .size_i(sz),
    .signed_i(signed_i), .mode64_i(mode64_i), .res_o(ld_res)
  );

  lsf_shr #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_shr (
    .opnd_i(data_i), .shamt_i(shamt_i), .wide_i(shift_wide_i),
    .arith_i(signed_i), .res_o(sh_res)
  );

  lsf_check #(.DATA_W(DATA_W)) i_check (
    .op_i(op), .size_i(sz), .off_i(addr_off_i), .mode64_i(mode64_i),
    .shift_wide_i(shift_wide_i), .trap_o(trap), .misalign_o(misalign)
  );

  assign do_wr = req_valid_i && (op == OP_LOAD || op == OP_SHR) && !trap && !misalign;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o    <= 1'b0;
      wr_data_o     <= '0;
      trap_o        <= 1'b0;
      align_fault_o <= 1'b0;
    end else begin
      wr_valid_o    <= do_wr;
      trap_o        <= req_valid_i && trap;
      align_fault_o <= req_valid_i && misalign && !trap;  // trap wins
      if (do_wr) wr_data_o <= (op == OP_LOAD) ? ld_res : sh_res;
    end
  end

  a_r10_trap_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !wr_valid_o && !align_fault_o);
  a_r10_trap_needs_compat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !$past(mode64_i) && $past(req_valid_i));
  a_r7_fault_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_fault_o |-> !wr_valid_o && $past(op_i) == 2'd0);
  a_r2_valid_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(req_valid_i));
  a_r11_wide_native_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && op_i == 2'd2 && mode64_i |=> !wr_valid_o && !trap_o && !align_fault_o);
  a_r4_compat_word_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && op_i == 2'd0 && size_i == 2'd2 && !mode64_i && addr_off_i[1:0] == 2'd0
    |=> wr_valid_o && wr_data_o[DATA_W-1:NARROW_W] == '0);
  a_r2_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_valid_i) |-> !wr_valid_o && $stable(wr_data_o));
endmodule

// File: tb/test_lsf_top.sv
`timescale 1ns/1ps
module test_lsf_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic        mode64_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic        signed_i = 1'b0;
  logic [2:0]  addr_off_i = '0;
  logic [5:0]  shamt_i = '0;
  logic        shift_wide_i = 1'b0;
  logic [63:0] data_i = '0;
  logic        wr_valid_o, trap_o, align_fault_o;
  logic [63:0] wr_data_o;

  int n_run = 0, n_fail = 0;
  bit done = 0, mon_on = 0;

  typedef struct {
    logic        v;
    logic [63:0] d;
    logic        t;
    logic        f;
    string       tag;
  } item_t;

  item_t exp_q[$];

  always #5 clk_i = ~clk_i;

  lsf_top i_lsf_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .op_i(op_i),
    .mode64_i(mode64_i), .size_i(size_i), .signed_i(signed_i),
    .addr_off_i(addr_off_i), .shamt_i(shamt_i), .shift_wide_i(shift_wide_i),
    .data_i(data_i), .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o),
    .trap_o(trap_o), .align_fault_o(align_fault_o)
  );

  function automatic item_t model(input logic [1:0] op, input logic m64,
      input logic [1:0] sz, input logic sg, input logic [2:0] off,
      input logic [5:0] sh, input logic wide, input logic [63:0] d, input string tag);
    item_t it;
    int nbytes;
    logic [63:0] r;
    logic fill;
    it.v = 0; it.d = 'x; it.t = 0; it.f = 0; it.tag = tag;
    if (!m64 && (op == 2 || (op == 0 && sz == 3) || (op == 1 && wide))) begin
      it.t = 1;
      return it;
    end
    if (op == 0) begin
      nbytes = 1 << sz;
      if ((off % nbytes) != 0) begin
        it.f = 1;
        return it;
      end
      r = '0;
      for (int i = 0; i < 8 * nbytes; i++) r[i] = d[8 * off + i];
      fill = (sz == 2) ? (m64 & r[31]) : (sz == 3) ? 1'b0 : (sg & r[8 * nbytes - 1]);
      for (int i = 8 * nbytes; i < 64; i++) r[i] = fill;
      it.v = 1; it.d = r;
    end else if (op == 1) begin
      r = '0;
      if (wide) begin
        fill = sg & d[63];
        for (int i = 0; i < 64; i++) r[i] = (i + sh < 64) ? d[i + sh] : fill;
      end else begin
        fill = sg & d[31];
        for (int i = 0; i < 32; i++) r[i] = (i + sh[4:0] < 32) ? d[i + sh[4:0]] : fill;
        for (int i = 32; i < 64; i++) r[i] = sg & r[31];
      end
      it.v = 1; it.d = r;
    end
    return it;
  endfunction

  task automatic issue(input logic [1:0] op, input logic m64, input logic [1:0] sz,
      input logic sg, input logic [2:0] off, input logic [5:0] sh, input logic wide,
      input logic [63:0] d, input string tag);
    @(negedge clk_i);
    req_valid_i = 1; op_i = op; mode64_i = m64; size_i = sz; signed_i = sg;
    addr_off_i = off; shamt_i = sh; shift_wide_i = wide; data_i = d;
    exp_q.push_back(model(op, m64, sz, sg, off, sh, wide, d, tag));
  endtask

  task automatic idle(input string tag);
    item_t it;
    @(negedge clk_i);
    req_valid_i = 0; op_i = 2'd0; data_i = 64'hDEAD_BEEF_0BAD_F00D;
    it.v = 0; it.d = 'x; it.t = 0; it.f = 0; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    if (mon_on && exp_q.size() > 0) begin
      item_t e;
      #1;
      e = exp_q.pop_front();
      chk({e.tag, " wr_valid"}, 64'(wr_valid_o), 64'(e.v));
      chk({e.tag, " trap"}, 64'(trap_o), 64'(e.t));
      chk({e.tag, " align_fault"}, 64'(align_fault_o), 64'(e.f));
      if (e.v === 1'b1) chk({e.tag, " wr_data"}, wr_data_o, e.d);
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  localparam logic [63:0] PAT = 64'h8877_6655_F433_2211;

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid", 64'(wr_valid_o), 64'd0);
    chk("R1 reset trap", 64'(trap_o), 64'd0);
    chk("R1 reset fault", 64'(align_fault_o), 64'd0);
    chk("R1 reset data", wr_data_o, 64'd0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 after release", 64'({wr_valid_o, trap_o, align_fault_o}), 64'd0);
    mon_on = 1;

    // R3 / R4 word loads, both lanes, both modes, both signed settings
    issue(0, 1, 2, 0, 4, 0, 0, 64'h8765_4321_0000_0000, "R3 word hi lane native");
    issue(0, 1, 2, 1, 0, 0, 0, 64'h0000_0000_7FFF_FFFF, "R3 word lo positive");
    issue(0, 0, 2, 1, 4, 0, 0, 64'h8765_4321_0000_0000, "R4 word compat signed");
    issue(0, 0, 2, 0, 0, 0, 0, 64'h1234_5678_9ABC_DEF0, "R4 word compat lo");
    idle("R2 gap");
    // R5 byte lanes and halfwords
    for (int k = 0; k < 8; k++) begin
      issue(0, k[0], 0, 1, 3'(k), 0, 0, PAT, "R5 byte signed");
      issue(0, 1, 0, 0, 3'(k), 0, 0, PAT, "R5 byte unsigned");
    end
    issue(0, 1, 1, 1, 6, 0, 0, PAT, "R5 half signed lane3");
    issue(0, 0, 1, 0, 2, 0, 0, PAT, "R5 half unsigned lane1");
    issue(0, 1, 1, 1, 0, 0, 0, PAT, "R5 half lane0");
    // R6
    issue(0, 1, 3, 0, 0, 0, 0, PAT, "R6 dword native");
    // R7 misaligned
    issue(0, 1, 1, 1, 1, 0, 0, PAT, "R7 half off1");
    issue(0, 0, 2, 0, 2, 0, 0, PAT, "R7 word off2");
    issue(0, 1, 3, 0, 4, 0, 0, PAT, "R7 dword off4");
    issue(0, 1, 2, 0, 4, 0, 0, PAT, "R2 load after fault");
    // R8 narrow shifts
    issue(1, 1, 0, 1, 0, 4, 0, 64'hFFFF_0000_8000_0000, "R8 narrow arith");
    issue(1, 0, 0, 0, 0, 4, 0, 64'hFFFF_0000_8000_0000, "R8 narrow logical");
    issue(1, 0, 0, 1, 0, 33, 0, 64'h0000_0000_8000_0010, "R8 narrow amount wraps");
    issue(1, 1, 0, 1, 0, 0, 0, 64'h0000_0000_9000_0001, "R8 narrow zero shift");
    issue(1, 1, 0, 1, 0, 31, 0, 64'h0000_0000_4000_0000, "R8 narrow positive");
    // R9 wide shifts
    issue(1, 1, 0, 1, 0, 8, 1, 64'h8000_0000_0000_00FF, "R9 wide arith");
    issue(1, 1, 0, 0, 0, 8, 1, 64'h8000_0000_0000_00FF, "R9 wide logical");
    issue(1, 1, 0, 1, 0, 63, 1, 64'h8000_0000_0000_0000, "R9 wide max");
    issue(1, 1, 0, 1, 0, 40, 1, 64'h0000_0001_8000_0000, "R9 fill from 63 not 31");
    // R10 traps
    issue(0, 0, 3, 0, 0, 0, 0, PAT, "R10 dword compat");
    issue(1, 0, 0, 1, 0, 4, 1, PAT, "R10 wide shift compat");
    issue(2, 0, 0, 0, 0, 0, 0, PAT, "R10 wide op compat");
    issue(0, 0, 3, 0, 3, 0, 0, PAT, "R10 trap over fault");
    issue(1, 0, 0, 0, 0, 4, 0, PAT, "R2 shift after trap");
    // R11
    issue(2, 1, 0, 0, 0, 0, 0, PAT, "R11 wide op native");
    issue(3, 1, 2, 1, 0, 0, 0, PAT, "R11 nop native");
    issue(3, 0, 3, 1, 5, 0, 1, PAT, "R11 nop compat");
    idle("R2 idle");
    idle("R2 idle");
    while (exp_q.size() > 0) @(negedge clk_i);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule